// File: doc/BRIEF.md
# Bus-Refreshed Watchdog Timer

A watchdog timer driven by one control byte on a simple register strobe interface. The byte carries a 5-bit multiplier and a 2-bit resolution code, and the timeout is their product counted in ticks of a slow timebase input. Every write to the control byte restarts the countdown, whatever value is written, so software keeps the watchdog alive by writing the byte again. A zero multiplier stops it.

When the countdown runs out, the block raises a one-cycle expiry pulse and sets a sticky flag. It then stops until the byte is written again. Reads of the control byte return the last value written.

The timebase input `tick_i` runs at 4^STEP_SHIFT pulses per second, which is 16 pulses per second by default. At that rate the two coarse resolution codes give 1-second and 4-second steps, and the two fine codes give sub-second steps.

Top module: `bus_wdt`

## Requirements
- R1: After reset the control byte reads 0x00, `expire_o` is low, `flag_o` is low and the watchdog is stopped.
- R2: A write with `addr_i` equal to REG_ADDR (0x09 by default) stores `wdata_i`. While `rd_i` is high and `addr_i` equals REG_ADDR, `rdata_o` shows the stored byte in the same cycle. Any other read shows 0x00.
- R3: Bits [6:2] of the control byte are the multiplier M. Bits [1:0] are the resolution code c, and one step lasts 4^c ticks: 1, 4, 16 or 64 ticks. At the default 16 ticks per second, c=2 is 1 s and c=3 is 4 s.
- R4: After a write that enables the watchdog, `expire_o` goes high in the clock cycle that follows the edge at which the (M·4^c)-th tick since the write is sampled. It is never earlier. The largest timeout is 31·64 ticks.
- R5: Every write to the control byte restarts the countdown from the full timeout, including a write of the value already held. A tick sampled in the same cycle as the write is not counted.
- R6: Writing 0x00, or any byte whose multiplier field is 0, stops the watchdog. No expiry follows, whatever the number of ticks.
- R7: With EXT_RES=1 (default), a written byte with bit 7 set is an invalid resolution. It stops the watchdog, but it is still stored and read back. With EXT_RES=0, bit 7 is stored and has no effect on timing.
- R8: `expire_o` is high for exactly one clock cycle per expiry. `flag_o` goes high at the same edge and stays high until the next write to the control byte.
- R9: After an expiry no further ticks are counted and no further expiry occurs until the control byte is written again.
- R10: A write to any other address does not change the control byte, does not restart the countdown and does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| tick_i | input | 1 | Timebase tick, one clock wide per tick |
| expire_o | output | 1 | One-cycle expiry pulse |
| flag_o | output | 1 | Sticky expiry flag |

## Verification
A wrong step counter or multiplier count shows up as an expiry pulse on the wrong tick, early or late. This is visible at `expire_o` and `flag_o` in the cycle right after the tick where the reference model expects the timeout. A missed reload or a lost run state shows up as a pulse after a keepalive write, or as a missing pulse after an enabling write. A stored byte that is corrupted appears on `rdata_o` in the same cycle it is read. The reference model therefore compares all three outputs on every clock, and the directed checks probe the last tick before each timeout and the timeout tick itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 8;
  localparam int MUL_W  = 5;
  localparam int RES_W  = 2;

  typedef struct packed {
    logic             ext;  // extra resolution bit
    logic [MUL_W-1:0] mul;
    logic [RES_W-1:0] res;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_reg.sv
module wdt_reg
  import wdt_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 9,
  parameter bit          EXT_RES  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output wdt_ctrl_t         ctrl_o,
  output logic              load_o,
  output logic              load_en_o,
  output logic [MUL_W-1:0]  load_mul_o
);
  wdt_ctrl_t ctrl_q;
  wdt_ctrl_t wr_ctrl;
  logic      hit;
  logic      ext_bad;

  assign wr_ctrl = wdt_ctrl_t'(wdata_i);
  assign hit     = wr_i && (addr_i == REG_ADDR);

  generate
    if (EXT_RES) begin : g_ext_chk
      assign ext_bad = wr_ctrl.ext;
    end else begin : g_ext_ign
      assign ext_bad = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (hit) ctrl_q <= wr_ctrl;
  end

  assign ctrl_o     = ctrl_q;
  assign load_o     = hit;
  assign load_en_o  = (wr_ctrl.mul != '0) && !ext_bad;
  assign load_mul_o = wr_ctrl.mul;
  assign rdata_o    = (rd_i && (addr_i == REG_ADDR)) ? DATA_W'(ctrl_q) : '0;

  AST_WR_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (DATA_W'(ctrl_q) == $past(wdata_i))); // R2
  AST_MISS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(ctrl_q)); // R10
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int STEP_SHIFT = 2,
  localparam int PRE_W = STEP_SHIFT * ((1 << RES_W) - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [RES_W-1:0] res_i,
  output logic             step_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim_m1;
  logic             at_lim;

  assign lim_m1 = PRE_W'((32'd1 << (STEP_SHIFT * 32'(res_i))) - 32'd1);
  assign at_lim = (pre_q == lim_m1);
  assign step_o = run_i && tick_i && !load_i && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if (load_i) pre_q <= '0;
    else if (run_i && tick_i) pre_q <= at_lim ? '0 : pre_q + 1'b1;
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= lim_m1); // R3
  AST_PRE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(pre_q)); // R9
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             load_en_i,
  input  logic [MUL_W-1:0] load_mul_i,
  input  logic             step_i,
  output logic             run_o,
  output logic             expire_o,
  output logic             flag_o
);
  logic [MUL_W-1:0] cnt_q;
  logic             run_q, exp_q, flag_q;
  logic             last;

  assign last = step_i && (cnt_q == MUL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      exp_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_mul_i;
      run_q  <= load_en_i;
      exp_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      exp_q <= last;
      if (last) begin
        run_q  <= 1'b0;
        flag_q <= 1'b1;
      end else if (step_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign run_o    = run_q;
  assign expire_o = exp_q;
  assign flag_o   = flag_q;

  AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_mul_i))); // R5
  AST_EXPIRE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |=> !exp_q); // R8
  AST_FLAG_WITH_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |-> flag_q); // R8
  AST_IDLE_NO_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !exp_q); // R9
  AST_RUN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0)); // R6
endmodule

// File: rtl/bus_wdt.sv
module bus_wdt
  import wdt_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 9,
  parameter bit                EXT_RES    = 1'b1,
  parameter int                STEP_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  output logic              expire_o,
  output logic              flag_o
);
  wdt_ctrl_t        ctrl;
  logic             load, load_en, run, step;
  logic [MUL_W-1:0] load_mul;

  wdt_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .EXT_RES(EXT_RES)) u_reg (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .ctrl_o(ctrl), .load_o(load), .load_en_o(load_en), .load_mul_o(load_mul)
  );

  wdt_prescale #(.STEP_SHIFT(STEP_SHIFT)) u_pre (
    .clk_i, .rst_ni, .load_i(load), .run_i(run), .tick_i, .res_i(ctrl.res),
    .step_o(step)
  );

  wdt_countdown u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_en_i(load_en), .load_mul_i(load_mul),
    .step_i(step), .run_o(run), .expire_o, .flag_o
  );

  AST_EXT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EXT_RES && wr_i && (addr_i == REG_ADDR) && wdata_i[7]) |=> !run); // R7
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == REG_ADDR)) |=> (!flag_o && !expire_o)); // R8
endmodule

// File: tb/bus_wdt_tb.sv
`timescale 1ns/1ps
module bus_wdt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b1, tick = 1'b0;
  logic [7:0] addr = 8'h09, wdata = 8'h00;
  logic [7:0] rdata;
  logic       expire, flag;

  int total = 0, fails = 0, exp_seen = 0;

  // reference model state
  logic [7:0] m_ctrl = 8'h00;
  int         m_remain = 0;
  bit         m_run = 0, m_exp = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  bus_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .expire_o(expire),
    .flag_o(flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h00; m_remain = 0; m_run = 0; m_exp = 0; m_flag = 0;
    end else begin
      m_exp = 0;
      if (wr && addr == 8'h09) begin
        m_ctrl   = wdata;
        m_flag   = 0;
        m_run    = (wdata[6:2] != 0) && !wdata[7];
        m_remain = int'(wdata[6:2]) * (4 ** int'(wdata[1:0]));
      end else if (tick && m_run) begin
        m_remain--;
        if (m_remain == 0) begin
          m_exp = 1; m_flag = 1; m_run = 0;
        end
      end
    end
    #1;
    if (rst_n) begin
      chk(expire == m_exp, "R4 expire_o model", int'(expire), int'(m_exp));
      chk(flag == m_flag, "R8 flag_o model", int'(flag), int'(m_flag));
      chk(rdata == ((rd && addr == 8'h09) ? m_ctrl : 8'h00), "R2 rdata_o model",
          int'(rdata), int'((rd && addr == 8'h09) ? m_ctrl : 8'h00));
      if (expire) exp_seen++;
    end
  end

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d, input bit with_tick);
    addr = a; wdata = d; wr = 1'b1; tick = with_tick;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0; addr = 8'h09;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog timeout");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata == 8'h00, "R1 reset rdata", int'(rdata), 0);
    chk(!expire, "R1 reset expire_o", int'(expire), 0);
    chk(!flag, "R1 reset flag_o", int'(flag), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ticks(10);
    chk(exp_seen == 0, "R1 stopped after reset", exp_seen, 0);

    // M=3, c=0 -> 3 ticks
    wr_byte(8'h09, 8'h0C, 0);
    chk(rdata == 8'h0C, "R2 readback", int'(rdata), 8'h0C);
    ticks(2);
    chk(!flag, "R4 before timeout", int'(flag), 0);
    ticks(1);
    chk(flag, "R4 at timeout", int'(flag), 1);
    chk(exp_seen == 1, "R8 one pulse", exp_seen, 1);
    ticks(5);
    chk(exp_seen == 1, "R9 no further expiry", exp_seen, 1);
    chk(flag, "R8 flag sticky", int'(flag), 1);

    wr_byte(8'h09, 8'h0C, 0);
    chk(!flag, "R8 write clears flag", int'(flag), 0);
    ticks(2);
    wr_byte(8'h09, 8'h0C, 0);  // same value keepalive
    ticks(2);
    chk(!flag, "R5 same-value reload", int'(flag), 0);
    ticks(1);
    chk(flag, "R5 timeout after reload", int'(flag), 1);

    // M=2, c=1 -> 8 ticks
    wr_byte(8'h09, 8'h09, 0);
    ticks(7); chk(!flag, "R3 code1 early", int'(flag), 0);
    ticks(1); chk(flag, "R3 code1 expiry", int'(flag), 1);
    // M=1, c=2 -> 16 ticks
    wr_byte(8'h09, 8'h06, 0);
    ticks(15); chk(!flag, "R3 code2 early", int'(flag), 0);
    ticks(1); chk(flag, "R3 code2 expiry", int'(flag), 1);
    // M=2, c=3 -> 128 ticks
    wr_byte(8'h09, 8'h0B, 0);
    ticks(127); chk(!flag, "R3 code3 early", int'(flag), 0);
    ticks(1); chk(flag, "R3 code3 expiry", int'(flag), 1);

    wr_byte(8'h09, 8'h00, 0);
    ticks(200);
    chk(!flag, "R6 zero byte stops", int'(flag), 0);
    chk(rdata == 8'h00, "R6 zero readback", int'(rdata), 0);
    wr_byte(8'h09, 8'h03, 0);
    ticks(100);
    chk(!flag, "R6 zero multiplier stops", int'(flag), 0);

    wr_byte(8'h09, 8'h8C, 0);
    ticks(20);
    chk(!flag, "R7 bit7 invalid stops", int'(flag), 0);
    chk(rdata == 8'h8C, "R7 bit7 stored", int'(rdata), 8'h8C);

    wr_byte(8'h09, 8'h0C, 0);
    ticks(2);
    wr_byte(8'h05, 8'h0C, 0);
    ticks(1);
    chk(flag, "R10 other address no reload", int'(flag), 1);
    wr_byte(8'h05, 8'h00, 0);
    chk(flag, "R10 other address keeps flag", int'(flag), 1);
    addr = 8'h05; @(negedge clk);
    chk(rdata == 8'h00, "R10 other address reads zero", int'(rdata), 0);
    addr = 8'h09; @(negedge clk);
    chk(rdata == 8'h0C, "R10 byte unchanged", int'(rdata), 8'h0C);

    wr_byte(8'h09, 8'h04, 1);  // tick with write is discarded
    chk(!flag, "R5 tick on write ignored", int'(flag), 0);
    ticks(1);
    chk(flag, "R5 first counted tick", int'(flag), 1);

    wr_byte(8'h09, 8'h7F, 0);  // M=31, c=3 -> 1984 ticks
    ticks(1983);
    chk(!flag, "R4 max before timeout", int'(flag), 0);
    ticks(1);
    chk(flag, "R4 max timeout", int'(flag), 1);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule